// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from 4-bit stages. The stages are chained into a wider counter that behaves as one binary register. Every state bit is a flip-flop on the same rising clock edge, so all output bits change together and no bit is clocked from another bit's output.

The counter has four operations, in this order of priority:
- an active-low clear;
- an active-low synchronous parallel load from a data input;
- a count, which needs both active-high enables, P and T;
- an inhibit (hold), used whenever none of the above applies.

Each stage makes a carry when its T input is high and its count is all ones. That carry drives the T input of the next stage, and P is shared by all stages. A chain of stages therefore counts as one wide counter with no extra gating.

A parameter chooses how the clear acts:
- **Synchronous clear:** the clear takes effect at the next clock edge. If a decode of a chosen terminal count is fed back into the clear, the counter runs with a shorter modulus.
- **Asynchronous clear:** the clear forces zero at once, with no clock edge.

Top module: `casc_counter`

## Requirements
- R1: All state bits are registered on the same rising clock edge. When counting, the whole WIDTH-bit value (WIDTH = STAGES*STAGE_BITS, bit 0 least significant) goes up by exactly one per edge. Starting from zero, the counter visits all 2^WIDTH states with no increment missed or repeated.
- R2: When load_n is low and the clear is inactive, q equals din after the next rising edge, whatever the levels of en_p and en_t.
- R3: With SYNC_CLEAR=1, clr_n low leaves q unchanged until the next rising edge. At that edge q becomes 0, overriding load_n, en_p and en_t.
- R4: With SYNC_CLEAR=0, clr_n low drives q to 0 at once, with no clock edge. This overrides the clock, load_n and both enables.
- R5: The counter advances only when clr_n and load_n are high and both en_p and en_t are high. In every other case with clear and load inactive, q holds its value.
- R6: carry_out is high exactly when en_t is high and q is all ones. With en_t low it stays low even if en_p is high.
- R7: Counting from the all-ones value wraps q to 0 on the next edge.
- R8: The following sequence is reproduced, watching the low nibble:
  - clear to 0;
  - preset to 12 (din = 8'hFC);
  - count through 13, 14, 15, 0, 1, 2;
  - hold when en_p goes low.
- R9: With SYNC_CLEAR=1, driving clr_n from a decode of q == K-1 makes the counter cycle through 0 to K-1.
- R10: Inside the chain, each stage's T input is the previous stage's carry, and en_p is common to all stages. A higher stage therefore increments only on the edge where every lower stage is at all ones and counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (synchronous or asynchronous per SYNC_CLEAR) |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable P, shared by all stages |
| en_t | input | 1 | Count enable T of the lowest stage; also gates carry_out |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Counter value |
| carry_out | output | 1 | Carry of the top stage: en_t high and q all ones |

## Verification
The bench targets a set of corner cases, each paired with the fault it would expose:
- **Wrap from all ones to zero across the stage boundary.** A broken carry chain leaves the upper nibble stuck, or increments it one state early.
- **Load while both enables are low.** A design that gates load with the enables ignores the preset.
- **Clear together with load.** A wrong priority loads din instead of zero.
- **Mid-cycle clear in both modes.** A mode swap shows up as an early zero on the synchronous copy, or a late zero on the asynchronous copy.
- **en_t low with en_p high at all ones.** A carry that ignores T pulses anyway.

The bench also runs a truncated modulus-10 loop and a full walk through all 2^WIDTH states.

// File: rtl/ctr_pkg.sv
// Package: types and helpers shared by the counter stages.
// Assumes: the priority among the operations is fixed as clear > load > count > hold.
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

    // Resolve the requested operation by the fixed priority.
    function automatic ctr_op_e pick_op(input logic clr_act,
                                        input logic load_act,
                                        input logic cnt_ok);
        if (clr_act)
            return OP_CLEAR;
        else if (load_act)
            return OP_LOAD;
        else if (cnt_ok)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_tc_decode.sv
// Module: terminal-count decode for one stage.
// Asserts all_ones when every bit of the stage value is 1.
// Assumes: BITS >= 1.
module ctr_tc_decode #(
    parameter int BITS = 4
) (
    input  logic [BITS-1:0] val,
    output logic            all_ones
);

    logic [BITS-1:0] chain;

    // Build a plain AND chain over the bits.
    genvar b;
    generate
        for (b = 0; b < BITS; b++) begin : g_and
            if (b == 0) begin : g_first
                assign chain[b] = val[b];
            end else begin : g_rest
                assign chain[b] = chain[b-1] & val[b];
            end
        end
    endgenerate

    assign all_ones = chain[BITS-1];

endmodule

// File: rtl/ctr_stage.sv
// Module: one presettable counter stage.
// Counts up when both enables are high. Loads d when load_n is low.
// Clears when clr_n is low, either at the next edge or at once, chosen by SYNC_CLEAR.
// rco is high when en_t is high and the stage is at all ones.
// Assumes: clr_n meets setup and release timing relative to clk.
module ctr_stage #(
    parameter int STAGE_BITS = 4,
    parameter bit SYNC_CLEAR = 1'b1
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic                  load_n,
    input  logic                  en_p,
    input  logic                  en_t,
    input  logic [STAGE_BITS-1:0] d,
    output logic [STAGE_BITS-1:0] q,
    output logic                  rco
);
    import ctr_pkg::*;

    localparam logic [STAGE_BITS-1:0] ONE = STAGE_BITS'(1);

    logic [STAGE_BITS-1:0] q_r;
    logic [STAGE_BITS-1:0] q_nxt;
    logic                  clr_sync_act;
    logic                  tc;
    ctr_op_e               op;

    // In asynchronous mode the clear is handled by the flop itself, not by the next-state logic.
    assign clr_sync_act = SYNC_CLEAR ? ~clr_n : 1'b0;

    // Pick this cycle's operation.
    always_comb op = pick_op(clr_sync_act, ~load_n, en_p & en_t);

    // Compute the next state for the chosen operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = d;
            OP_COUNT: q_nxt = q_r + ONE;
            default:  q_nxt = q_r;
        endcase
    end

    generate
        if (SYNC_CLEAR) begin : g_sync_clr
            // State register; the clear arrives through q_nxt.
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end else begin : g_async_clr
            // State register with an immediate clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q_r <= '0;
                else
                    q_r <= q_nxt;
            end
        end
    endgenerate

    ctr_tc_decode #(.BITS(STAGE_BITS)) u_tc (
        .val      (q_r),
        .all_ones (tc)
    );

    // Carry is enabled by T only.
    assign rco = en_t & tc;
    assign q   = q_r;

endmodule

// File: rtl/casc_counter.sv
// Module: chain of STAGES counter stages that forms one WIDTH-bit counter.
// Stage i takes its T enable from the carry of stage i-1. P, load, clear and the clock are shared.
// Assumes: STAGES >= 1.
module casc_counter #(
    parameter int STAGES     = 2,
    parameter int STAGE_BITS = 4,
    parameter bit SYNC_CLEAR = 1'b1,
    localparam int WIDTH     = STAGES * STAGE_BITS
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    logic [STAGES-1:0] t_in;
    logic [STAGES-1:0] rco;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Feed T from the external enable or from the carry of the stage below.
            if (s == 0) begin : g_t0
                assign t_in[s] = en_t;
            end else begin : g_tn
                assign t_in[s] = rco[s-1];
            end

            ctr_stage #(
                .STAGE_BITS (STAGE_BITS),
                .SYNC_CLEAR (SYNC_CLEAR)
            ) u_stage (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_p   (en_p),
                .en_t   (t_in[s]),
                .d      (din[s*STAGE_BITS +: STAGE_BITS]),
                .q      (q[s*STAGE_BITS +: STAGE_BITS]),
                .rco    (rco[s])
            );
        end
    endgenerate

    assign carry_out = rco[STAGES-1];

endmodule

// File: rtl/casc_counter_chk.sv
// Checker: temporal properties of the counter chain, seen at its ports.
module casc_counter_chk #(
    parameter int WIDTH      = 8,
    parameter bit SYNC_CLEAR = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    logic started = 1'b0;

    // Mark that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) started <= 1'b1;

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));  // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        load_n && en_p && en_t |=> q == WIDTH'($past(q) + 1'b1));  // R1

    AST_HOLD_WHEN_INHIBIT: assert property (@(posedge clk) disable iff (!clr_n)
        load_n && !(en_p && en_t) |=> $stable(q));  // R5

    AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!started)
        carry_out |-> en_t && (&q));  // R6

    AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!started)
        en_t && (&q) |-> carry_out);  // R6

    generate
        if (SYNC_CLEAR) begin : g_sync
            AST_SYNC_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!started)
                $past(!clr_n) |-> q == '0);  // R3
        end else begin : g_async
            AST_ASYNC_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!started)
                !clr_n |-> q == '0);  // R4
        end
    endgenerate

endmodule

bind casc_counter casc_counter_chk #(
    .WIDTH      (WIDTH),
    .SYNC_CLEAR (SYNC_CLEAR)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_p      (en_p),
    .en_t      (en_t),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/casc_counter_tb_top.sv
// Bench: a synchronous-clear copy and an asynchronous-clear copy, checked against a model.
module casc_counter_tb_top;

    localparam int W = 8;
    localparam logic [W-1:0] MAX = '1;

    logic         clk = 1'b0;
    logic         clr_n_s = 1'b0, clr_n_a = 1'b0;
    logic         load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_s, q_a;
    logic         co_s, co_a;
    logic [W-1:0] exp_s, exp_a;
    int           n_vec = 0, n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    casc_counter #(.STAGES(2), .STAGE_BITS(4), .SYNC_CLEAR(1'b1)) dut_i (
        .clk(clk), .clr_n(clr_n_s), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q_s), .carry_out(co_s));

    casc_counter #(.STAGES(2), .STAGE_BITS(4), .SYNC_CLEAR(1'b0)) dut_async_i (
        .clk(clk), .clr_n(clr_n_a), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q_a), .carry_out(co_a));

    // Reference next state, by priority.
    function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic c_n);
        if (!c_n)                return '0;
        else if (!load_n)        return din;
        else if (en_p && en_t)   return cur + 1'b1;
        else                     return cur;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply the current inputs for one edge, then check both copies.
    task automatic tick(input string tag);
        logic [W-1:0] ns, na;
        ns = model(exp_s, clr_n_s);
        na = model(exp_a, clr_n_a);
        @(posedge clk);
        #2;
        chk(tag, q_s, ns);
        chk(tag, q_a, na);
        exp_s = ns;
        exp_a = na;
        chk("R6", W'(co_s), W'(en_t && exp_s == MAX));
        chk("R6", W'(co_a), W'(en_t && exp_a == MAX));
        @(negedge clk);
    endtask

    task automatic set(input logic c, input logic ld, input logic p, input logic t,
                       input logic [W-1:0] d);
        clr_n_s = c; clr_n_a = c; load_n = ld; en_p = p; en_t = t; din = d;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // Reset state: clear with both enables and load active.
        set(1'b0, 1'b0, 1'b1, 1'b1, 8'h77);
        tick("R3 reset/clear over load");

        // R8: the clear, preset and count sequence, then hold.
        set(1'b1, 1'b0, 1'b0, 1'b0, 8'hFC);
        tick("R2 load while disabled");
        chk("R8", q_s, 8'hFC);
        set(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 6; i++) begin
            tick("R8");
            chk("R8 low nibble", W'(q_s[3:0]), W'((13 + i) % 16));
        end
        chk("R7 wrap", q_s, 8'h02);
        en_p = 1'b0;
        tick("R5 hold");
        chk("R8 inhibit", q_s, 8'h02);

        // R6: T low blocks the carry at all ones while P is high.
        set(1'b1, 1'b0, 1'b1, 1'b0, 8'hFF);
        tick("R2");
        set(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R6 T low", W'(co_s), '0);
        tick("R5 T low holds");
        en_t = 1'b1;
        #1 chk("R6 T high", W'(co_s), 8'h01);
        tick("R7 wrap");

        // R10: carry crosses the stage boundary only from x F to (x+1) 0.
        set(1'b1, 1'b0, 1'b1, 1'b1, 8'h3F);
        tick("R2");
        set(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        tick("R10");
        chk("R10 boundary", q_s, 8'h40);

        // R3 and R4: a mid-cycle clear.
        set(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
        tick("R2");
        clr_n_s = 1'b0; clr_n_a = 1'b0;
        #2;
        chk("R4 async immediate", q_a, 8'h00);
        chk("R3 sync waits for edge", q_s, 8'h5A);
        tick("R3");
        set(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        tick("R5");

        // R1 and R10: walk the whole state space.
        set(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 256; i++) tick("R1 full walk");
        chk("R1 full cycle returns", q_s, 8'h00);

        // R9: modulus-10 loop from the decode of q == 9 (sync copy only).
        set(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        tick("R2");
        load_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            clr_n_s = (exp_s != 8'd9);
            tick("R9 modulus 10");
            chk("R9 sequence", q_s, W'((i + 1) % 10));
        end

        // Random stimulus.
        for (int i = 0; i < 3000; i++) begin
            set(($urandom % 32) != 0, ($urandom % 8) != 0,
                ($urandom % 4) != 0, ($urandom % 4) != 0, W'($urandom));
            tick("R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule